// File: doc/BRIEF.md
# PCM Receive FIFO with Level Trigger

This block is the receive buffer that sits between one audio channel's decimation filter output and the system bus. Each PCM sample arrives with a programmable word size. The block widens it to a 32-bit word, filling the upper bits with zeros or with copies of the sample's sign bit. It then stores the word in a 64-entry first-in first-out buffer.

On the read side, the oldest entry is always visible on the read data port. A pop removes that entry. Looking at the port without popping is a silent read that leaves every piece of state untouched. The current fill count is always available.

Three sticky interrupt causes are kept: trigger, overflow and underflow. The trigger cause is set when the fill count exceeds a programmable level. Causes are cleared by writing ones and can be forced through a separate set input for test. A mask selects which causes drive the interrupt line. An unmasked, level-sensitive DMA request follows the trigger condition directly. A freeze input holds the buffer contents and pointers still for debug.

Top module: `pcm_rx_fifo`

## Requirements
- R1: The buffer holds up to 64 words and returns them in arrival order. `fill_count` reports 0 to 64. A push is accepted whenever the buffer is not full and freeze is low.
- R2: `word_size` maps codes to widths as follows: 0→8, 1→10, 2→12, 3→14, 4→16, 5→18, 6→20, 7→24, 8→32. Codes 9 to 15 are treated as 32. With `sign_ext`=0, the stored word holds the low width bits of `wr_sample` and has zeros above them.
- R3: With `sign_ext`=1, every bit above the width is a copy of bit width-1 of `wr_sample`.
- R4: `rd_data` shows the oldest entry combinationally, and shows 0 while the buffer is empty. Observing it without `rd_pop` changes nothing. A pop of a non-empty buffer removes the head.
- R5: A push while full, with freeze low, sets cause bit 1 (overflow). The sample is dropped and the stored contents are unchanged. In the same cycle a pop of the full buffer is still honoured.
- R6: A pop while empty, with freeze low, sets cause bit 2 (underflow). The pointers stay put and `rd_data` stays 0. A push in the same cycle is still accepted.
- R7: `dma_req` is high exactly while `fill_count` > `trig_level`, regardless of the mask. Cause bit 0 (trigger) is set on the clock edge that follows any cycle in which that holds.
- R8: While `freeze` is high, pushes and pops are ignored, and overflow and underflow are not raised.
- R9: Causes are sticky. A one in `irq_clr` clears that bit. A one in `irq_set` sets it. If a hardware event or a set meets a clear in the same cycle, the bit ends up set.
- R10: `irq_masked` is the bitwise AND of the causes and `irq_mask`. `irq` is high when any masked bit is high.
- R11: After reset the buffer is empty, all causes are 0, and `dma_req`, `irq` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Push one sample this cycle |
| wr_sample | input | 32 | Raw sample, significant bits at the bottom |
| word_size | input | 4 | Sample width code |
| sign_ext | input | 1 | 1 = sign fill, 0 = zero fill |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 32 | Head entry, or 0 when empty |
| fill_count | output | 7 | Number of stored words |
| trig_level | input | 6 | Trigger threshold |
| freeze | input | 1 | Hold buffer state for debug |
| irq_clr | input | 3 | Write-one-to-clear strobe per cause |
| irq_set | input | 3 | Force strobe per cause |
| irq_mask | input | 3 | Cause enable for `irq` |
| irq_cause | output | 3 | Sticky causes: bit0 trigger, bit1 overflow, bit2 underflow |
| irq_masked | output | 3 | Causes ANDed with mask |
| irq | output | 1 | OR of the masked causes |
| dma_req | output | 1 | Level request while fill exceeds threshold |

## Verification
The directed stimulus covers several cases. Negative and positive samples are tried at 8, 16 and 24 bits with both fill modes, which separates the sign-fill path from the zero-fill path and a wrong width decode from a wrong fill bit. Filling to capacity and pushing once more distinguishes a dropped sample from an overwrite. Draining past empty distinguishes a held pointer from one that wraps. Freeze is applied while the buffer is full and while a clear meets a fresh event, which exposes any leak of pops, pushes or causes. A long mixed run then covers random word sizes, thresholds, mask values and strobes, so that ordering and the count compare are exercised across pointer wrap.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  localparam int WORD_W  = 32;
  localparam int CAUSE_N = 3;
  localparam int C_TRIG  = 0;
  localparam int C_OVF   = 1;
  localparam int C_UDF   = 2;

  // width in bits selected by a 4-bit size code
  function automatic int unsigned code_width(input logic [3:0] code);
    case (code)
      4'd0: return 8;
      4'd1: return 10;
      4'd2: return 12;
      4'd3: return 14;
      4'd4: return 16;
      4'd5: return 18;
      4'd6: return 20;
      4'd7: return 24;
      default: return 32;
    endcase
  endfunction

  // place a sample into a full word, filling above its width
  function automatic logic [WORD_W-1:0] pack_word(input logic [WORD_W-1:0] s,
                                                  input logic [3:0] code,
                                                  input logic sext);
    int unsigned w;
    logic fill;
    logic [WORD_W-1:0] r;
    w    = code_width(code);
    fill = sext & s[w-1];
    for (int i = 0; i < WORD_W; i++) begin
      r[i] = (i < int'(w)) ? s[i] : fill;
    end
    return r;
  endfunction
endpackage

// File: rtl/pcm_word_packer.sv
module pcm_word_packer
  import pcm_fifo_pkg::*;
(
  input  logic [WORD_W-1:0] sample,
  input  logic [3:0]        size_code,
  input  logic              sext,
  output logic [WORD_W-1:0] word
);
  always_comb word = pack_word(sample, size_code, sext);
endmodule

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/pcm_irq_ctrl.sv
module pcm_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] set,
  input  logic [N-1:0] mask,
  output logic [N-1:0] cause,
  output logic [N-1:0] masked,
  output logic         any
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cause[b] <= 1'b0;
      else if (hw_evt[b] | set[b]) cause[b] <= 1'b1;
      else if (clr[b])            cause[b] <= 1'b0;
    end
    assign masked[b] = cause[b] & mask[b];
  end
  assign any = |masked;
endmodule

// File: rtl/pcm_rx_fifo.sv
module pcm_rx_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_sample,
  input  logic [3:0]         word_size,
  input  logic               sign_ext,
  input  logic               rd_pop,
  output logic [WORD_W-1:0]  rd_data,
  output logic [CW-1:0]      fill_count,
  input  logic [LW-1:0]      trig_level,
  input  logic               freeze,
  input  logic [CAUSE_N-1:0] irq_clr,
  input  logic [CAUSE_N-1:0] irq_set,
  input  logic [CAUSE_N-1:0] irq_mask,
  output logic [CAUSE_N-1:0] irq_cause,
  output logic [CAUSE_N-1:0] irq_masked,
  output logic               irq,
  output logic               dma_req
);
  logic [WORD_W-1:0]  packed_word, head_word;
  logic               full, empty;
  logic               push_ok, pop_ok, ovf_evt, udf_evt, trig_hit;
  logic [CAUSE_N-1:0] hw_evt;

  pcm_word_packer u_pack (
    .sample(wr_sample), .size_code(word_size), .sext(sign_ext), .word(packed_word)
  );

  assign full    = (fill_count == CW'(DEPTH));
  assign empty   = (fill_count == '0);
  assign push_ok = wr_valid & ~freeze & ~full;
  assign pop_ok  = rd_pop & ~freeze & ~empty;
  assign ovf_evt = wr_valid & ~freeze & full;
  assign udf_evt = rd_pop & ~freeze & empty;
  assign trig_hit = (fill_count > CW'(trig_level));

  pcm_fifo_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok),
    .din(packed_word), .head(head_word), .count(fill_count)
  );

  always_comb begin
    hw_evt         = '0;
    hw_evt[C_TRIG] = trig_hit;
    hw_evt[C_OVF]  = ovf_evt;
    hw_evt[C_UDF]  = udf_evt;
  end

  pcm_irq_ctrl #(.N(CAUSE_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .clr(irq_clr), .set(irq_set),
    .mask(irq_mask), .cause(irq_cause), .masked(irq_masked), .any(irq)
  );

  assign rd_data = empty ? '0 : head_word;
  assign dma_req = trig_hit;
endmodule

// File: rtl/pcm_rx_fifo_chk.sv
module pcm_rx_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rd_pop,
  input logic          freeze,
  input logic [CW-1:0] fill_count,
  input logic [31:0]   rd_data,
  input logic [2:0]    irq_cause,
  input logic          dma_req,
  input logic          ovf_evt,
  input logic          udf_evt
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq_cause[1]);

  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> irq_cause[2]);

  // R6
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> (rd_data == '0));

  // R7
  trig_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> irq_cause[0]);

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(fill_count));

  // R8
  freeze_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !(ovf_evt || udf_evt));

  // R4
  pop_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !wr_valid && !freeze && fill_count != '0)
      |=> fill_count == CW'($past(fill_count) - 1'b1));
endmodule

bind pcm_rx_fifo pcm_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
  .freeze(freeze), .fill_count(fill_count), .rd_data(rd_data),
  .irq_cause(irq_cause), .dma_req(dma_req), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
);

// File: tb/sim_pcm_rx_fifo.sv
`timescale 1ns/1ps
module sim_pcm_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, sx_i = 1, frz_i = 0;
  logic [31:0] smp_i = '0;
  logic [3:0]  ws_i = '0;
  logic [5:0]  lvl_i = '0;
  logic [2:0]  clr_i = '0, set_i = '0, mask_i = '0;
  logic [31:0] rd_data;
  logic [6:0]  fill_count;
  logic [2:0]  irq_cause, irq_masked;
  logic        irq, dma_req;

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  logic [2:0]  m_cause = '0;

  always #2.5 clk = ~clk;

  pcm_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(push_i), .wr_sample(smp_i),
    .word_size(ws_i), .sign_ext(sx_i), .rd_pop(pop_i), .rd_data(rd_data),
    .fill_count(fill_count), .trig_level(lvl_i), .freeze(frz_i),
    .irq_clr(clr_i), .irq_set(set_i), .irq_mask(mask_i),
    .irq_cause(irq_cause), .irq_masked(irq_masked), .irq(irq), .dma_req(dma_req)
  );

  function automatic int bits_of(input logic [3:0] c);
    if (c <= 4'd6) return 8 + 2 * int'(c);
    if (c == 4'd7) return 24;
    return 32;
  endfunction

  function automatic logic [31:0] widen(input logic [31:0] s, input logic [3:0] c, input logic sx);
    int w = bits_of(c);
    longint unsigned keep = (64'd1 << w) - 1;
    longint unsigned r = longint'(s) & keep;
    if (sx && s[w-1]) r = r | ~keep;
    return r[31:0];
  endfunction

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] hd;
    hd = (q.size() > 0) ? q[0] : 32'd0;
    expect32("R1 fill_count", 32'(fill_count), 32'(q.size()));
    expect32("R4 rd_data", rd_data, hd);
    expect32("R9 irq_cause", 32'(irq_cause), 32'(m_cause));
    expect32("R10 irq_masked", 32'(irq_masked), 32'(m_cause & mask_i));
    expect32("R10 irq", 32'(irq), 32'((m_cause & mask_i) != 0));
    expect32("R7 dma_req", 32'(dma_req), 32'(q.size() > int'(lvl_i)));
  endtask

  task automatic model_update();
    int n = q.size();
    logic [2:0] ev = '0;
    ev[0] = (n > int'(lvl_i));
    if (!frz_i) begin
      ev[1] = push_i && n == 64;
      ev[2] = pop_i && n == 0;
      if (pop_i && n > 0) void'(q.pop_front());
      if (push_i && n < 64) q.push_back(widen(smp_i, ws_i, sx_i));
    end
    m_cause = (m_cause & ~clr_i) | ev | set_i;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    push_i = 0; pop_i = 0; clr_i = '0; set_i = '0;
  endtask

  task automatic push1(input logic [31:0] s, input logic [3:0] c, input logic sx);
    quiet(); push_i = 1; smp_i = s; ws_i = c; sx_i = sx; tick(); quiet();
  endtask

  task automatic pop1();
    quiet(); pop_i = 1; tick(); quiet();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    lvl_i = 6'd63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    compare_all();
    expect32("R11 fill_count after reset", 32'(fill_count), 0);
    expect32("R11 cause after reset", 32'(irq_cause), 0);
    expect32("R11 dma after reset", 32'(dma_req), 0);

    // R2 zero fill, R3 sign fill
    push1(32'h0000_0080, 4'd0, 1'b0);
    expect32("R2 8-bit zero fill", rd_data, 32'h0000_0080);
    pop1();
    push1(32'hABCD_1280, 4'd0, 1'b1);
    expect32("R3 8-bit sign fill", rd_data, 32'hFFFF_FF80);
    push1(32'h0080_0000, 4'd7, 1'b1);
    push1(32'h1234_7FFF, 4'd4, 1'b1);
    push1(32'hFFFF_9000, 4'd4, 1'b0);
    // R4 silent read leaves state alone
    tick(); tick();
    expect32("R4 peek keeps head", rd_data, 32'hFFFF_FF80);
    expect32("R4 peek keeps count", 32'(fill_count), 4);
    pop1();
    expect32("R3 24-bit sign fill", rd_data, 32'hFF80_0000);
    pop1();
    expect32("R3 16-bit positive", rd_data, 32'h0000_7FFF);
    pop1();
    expect32("R2 16-bit zero fill", rd_data, 32'h0000_9000);
    pop1();

    // R7 threshold compare
    lvl_i = 6'd5;
    for (int i = 0; i < 5; i++) push1(32'(i), 4'd8, 1'b0);
    expect32("R7 no dma at level", 32'(dma_req), 0);
    push1(32'h55, 4'd8, 1'b0);
    expect32("R7 dma above level", 32'(dma_req), 1);
    tick();
    expect32("R7 trigger cause set", 32'(irq_cause[0]), 1);

    // R5 overflow drops sample
    for (int i = 6; i < 64; i++) push1(32'(i * 3), 4'd8, 1'b0);
    expect32("R1 full count", 32'(fill_count), 64);
    push1(32'hDEAD_BEEF, 4'd8, 1'b0);
    expect32("R5 overflow cause", 32'(irq_cause[1]), 1);
    expect32("R5 count held", 32'(fill_count), 64);
    expect32("R5 head intact", rd_data, 32'd0);

    // R9 clear, R8 freeze
    quiet(); clr_i = 3'b111; tick(); quiet();
    expect32("R9 ovf cleared", 32'(irq_cause[2:1]), 0);
    frz_i = 1;
    quiet(); push_i = 1; pop_i = 1; smp_i = 32'h77; tick(); tick(); quiet();
    expect32("R8 frozen count", 32'(fill_count), 64);
    expect32("R8 no causes while frozen", 32'(irq_cause[2:1]), 0);
    frz_i = 0;

    // drain, R6 underflow
    for (int i = 0; i < 64; i++) pop1();
    expect32("R1 drained", 32'(fill_count), 0);
    pop1();
    expect32("R6 underflow cause", 32'(irq_cause[2]), 1);
    expect32("R6 empty read zero", rd_data, 32'd0);
    push1(32'h3C, 4'd0, 1'b0);
    expect32("R6 pointer held", rd_data, 32'h3C);
    pop1();

    // R9 event beats clear, R10 mask
    quiet(); pop_i = 1; clr_i = 3'b100; tick(); quiet();
    expect32("R9 event wins clear", 32'(irq_cause[2]), 1);
    quiet(); clr_i = 3'b111; tick(); quiet();
    quiet(); set_i = 3'b010; mask_i = 3'b100; tick(); quiet();
    expect32("R9 forced cause", 32'(irq_cause), 3'b010);
    expect32("R10 masked off", 32'(irq), 0);
    mask_i = 3'b010; tick();
    expect32("R10 masked on", 32'(irq), 1);

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      quiet();
      push_i = ($urandom_range(9) < 6);
      pop_i  = ($urandom_range(9) < 5);
      smp_i  = $urandom;
      ws_i   = 4'($urandom_range(15));
      sx_i   = 1'($urandom_range(1));
      frz_i  = ($urandom_range(19) == 0);
      if ($urandom_range(15) == 0) lvl_i = 6'($urandom_range(63));
      clr_i  = 3'($urandom_range(7)) & {3{$urandom_range(3) == 0}};
      set_i  = ($urandom_range(31) == 0) ? 3'($urandom_range(7)) : 3'b000;
      mask_i = 3'($urandom_range(7));
      tick();
    end
    quiet(); frz_i = 0;
    finish_run();
  end
endmodule